// File: doc/BRIEF.md
# Packet Framing Protocol Checker

This block is a passive monitor for a one-way link that uses valid/busy flow control. A beat crosses the link only on a clock edge where the sender holds valid high and the receiver holds busy low. The monitor reads the command field of each such beat. It checks that the beats follow the packet grammar: one opening beat, then any number of body beats (zero is allowed), then one closing beat.

Cycles in which the link is stalled or idle are skipped, so holding a beat for many cycles never looks like a repeated beat. When a rule is broken, the monitor does four things:

- it raises a one-cycle error pulse;
- it records which rule failed in a code register;
- it sets a flag that stays set until reset;
- it recovers its framing state so that checking continues on the beats that follow.

Each packet that closes legally produces a one-cycle completion pulse. The monitor drives nothing back onto the link.

Top module: `pkt_frame_mon`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the error flag, the error code, the error pulse and the completion pulse are all 0. The framing state is "outside a packet".
- R2: A beat is evaluated only on a rising edge with valid = 1 and busy = 0. On any other edge the outputs and the framing state keep their values, whatever command or data the link carries, except that both pulses return to 0.
- R3: Command values are decoded as follows: 24'h000001 opens a packet, 24'h000002 is a body beat, and 24'h000003 closes a packet. The data field never affects any output.
- R4: An accepted close beat that arrives inside a packet raises the completion pulse for exactly one cycle, in the cycle after the beat. It raises no error, and it returns the state to outside a packet.
- R5: An accepted open beat that arrives inside a packet is an error with code 2'd1. The beat still opens a new packet, so the state stays inside a packet.
- R6: An accepted body or close beat that arrives outside a packet is an error with code 2'd2. The state stays outside a packet and no completion pulse follows.
- R7: An accepted beat whose command is none of the three values is an error with code 2'd3. It leaves the framing state unchanged.
- R8: Each error beat raises the error pulse for exactly one cycle, in the cycle after the beat. The error code register then holds that beat's code until the next error beat or reset.
- R9: The error flag rises together with the first error pulse. It stays 1 until reset.
- R10: An open beat is legal outside a packet, including as the first accepted beat after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lnk_valid | input | 1 | Sender has a beat on the link |
| lnk_busy | input | 1 | Receiver refuses the beat this cycle |
| lnk_cmd | input | 24 | Command field of the beat |
| lnk_data | input | 32 | Data field of the beat (observed, not checked) |
| err_flag | output | 1 | Sticky: some framing error has occurred since reset |
| err_code | output | 2 | Code of the latest error (1 open-in-packet, 2 outside-packet, 3 bad command) |
| err_pulse | output | 1 | One cycle after each erroneous accepted beat |
| pkt_done | output | 1 | One cycle after each legal packet close |

## Verification
The hardest case to reach is an erroneous beat that is not accepted. This means a command held on the link while busy is high, or driven while valid is low, with an error code already latched. Such a beat must change neither the recorded code nor the framing state.

The stimulus drives deliberate protocol violations first. It then parks illegal, opening and closing commands on stalled cycles in between accepted beats. A later legal close or a fresh error shows whether the hidden state moved. A long seeded random stream then mixes all four command kinds with random valid and busy, and a behavioural model is compared against the outputs on every clock.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

  typedef enum logic [1:0] {
    BK_OPEN  = 2'd0,
    BK_BODY  = 2'd1,
    BK_CLOSE = 2'd2,
    BK_BAD   = 2'd3
  } beat_kind_e;

  typedef enum logic {
    FS_OUT = 1'b0,
    FS_IN  = 1'b1
  } frame_st_e;

  localparam int ERR_W = 2;

  localparam logic [ERR_W-1:0] ERR_NONE     = 2'd0;
  localparam logic [ERR_W-1:0] ERR_OPEN_IN  = 2'd1;
  localparam logic [ERR_W-1:0] ERR_OUTSIDE  = 2'd2;
  localparam logic [ERR_W-1:0] ERR_BAD_CMD  = 2'd3;

  // Violation code for a beat of the given kind seen in the given state.
  function automatic logic [ERR_W-1:0] frame_violation(frame_st_e st, beat_kind_e kind);
    logic [ERR_W-1:0] code;
    code = ERR_NONE;
    unique case (kind)
      BK_BAD:   code = ERR_BAD_CMD;
      BK_OPEN:  code = (st == FS_IN) ? ERR_OPEN_IN : ERR_NONE;
      BK_BODY,
      BK_CLOSE: code = (st == FS_OUT) ? ERR_OUTSIDE : ERR_NONE;
      default:  code = ERR_NONE;
    endcase
    return code;
  endfunction

  // Framing state after a beat; bad commands leave it alone.
  function automatic frame_st_e frame_next(frame_st_e st, beat_kind_e kind);
    frame_st_e nx;
    nx = st;
    unique case (kind)
      BK_OPEN:  nx = FS_IN;
      BK_CLOSE: nx = FS_OUT;
      default:  nx = st;
    endcase
    return nx;
  endfunction

  // A close beat that legally ends a packet.
  function automatic logic frame_closes(frame_st_e st, beat_kind_e kind);
    return (st == FS_IN) && (kind == BK_CLOSE);
  endfunction

endpackage

// File: rtl/pkt_beat_decode.sv
module pkt_beat_decode
  import pkt_frame_pkg::*;
#(
  parameter int              CMD_W   = 24,
  parameter int              DATA_W  = 32,
  parameter logic [CMD_W-1:0] CMD_OPEN  = 24'h000001,
  parameter logic [CMD_W-1:0] CMD_BODY  = 24'h000002,
  parameter logic [CMD_W-1:0] CMD_CLOSE = 24'h000003
) (
  input  logic              valid,
  input  logic              busy,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] data,
  output logic              accepted,
  output beat_kind_e        kind
);

  // Data is carried on the link but plays no part in framing.
  logic unused_data_parity;
  assign unused_data_parity = ^data;

  assign accepted = valid && !busy;

  always_comb begin
    if (cmd == CMD_OPEN)       kind = BK_OPEN;
    else if (cmd == CMD_BODY)  kind = BK_BODY;
    else if (cmd == CMD_CLOSE) kind = BK_CLOSE;
    else                       kind = BK_BAD;
  end

endmodule

// File: rtl/pkt_frame_fsm.sv
module pkt_frame_fsm
  import pkt_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accepted,
  input  beat_kind_e       kind,
  output logic             in_pkt,
  output logic [ERR_W-1:0] viol_code,
  output logic             closes
);

  frame_st_e st_q;

  assign in_pkt    = (st_q == FS_IN);
  assign viol_code = accepted ? frame_violation(st_q, kind) : ERR_NONE;
  assign closes    = accepted && frame_closes(st_q, kind);

  always_ff @(posedge clk) begin
    if (rst)           st_q <= FS_OUT;
    else if (accepted) st_q <= frame_next(st_q, kind);
  end

  a_r5_open_lands_inside: assert property (@(posedge clk) disable iff (rst)
    (accepted && kind == BK_OPEN) |=> in_pkt);

  a_r6_outside_stays_out: assert property (@(posedge clk) disable iff (rst)
    (accepted && !in_pkt && (kind == BK_BODY || kind == BK_CLOSE)) |=> !in_pkt);

  a_r7_bad_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (accepted && kind == BK_BAD) |=> (in_pkt == $past(in_pkt)));

  a_r2_stall_holds_state: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> $stable(in_pkt));

endmodule

// File: rtl/pkt_err_report.sv
module pkt_err_report
  import pkt_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] viol_code,
  input  logic             closes,
  output logic             err_flag,
  output logic [ERR_W-1:0] err_code,
  output logic             err_pulse,
  output logic             pkt_done
);

  logic viol_now;
  assign viol_now = (viol_code != ERR_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag  <= 1'b0;
      err_code  <= ERR_NONE;
      err_pulse <= 1'b0;
      pkt_done  <= 1'b0;
    end else begin
      err_pulse <= viol_now;
      pkt_done  <= closes;
      if (viol_now) begin
        err_flag <= 1'b1;
        err_code <= viol_code;
      end
    end
  end

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  a_r8_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_flag && err_code != ERR_NONE));

  a_r8_code_holds_quiet: assert property (@(posedge clk) disable iff (rst)
    !viol_now |=> $stable(err_code));

  a_r4_done_not_error: assert property (@(posedge clk) disable iff (rst)
    !(pkt_done && err_pulse));

endmodule

// File: rtl/pkt_frame_mon.sv
module pkt_frame_mon
  import pkt_frame_pkg::*;
#(
  parameter int               CMD_W     = 24,
  parameter int               DATA_W    = 32,
  parameter logic [CMD_W-1:0] CMD_OPEN  = 24'h000001,
  parameter logic [CMD_W-1:0] CMD_BODY  = 24'h000002,
  parameter logic [CMD_W-1:0] CMD_CLOSE = 24'h000003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lnk_valid,
  input  logic              lnk_busy,
  input  logic [CMD_W-1:0]  lnk_cmd,
  input  logic [DATA_W-1:0] lnk_data,
  output logic              err_flag,
  output logic [ERR_W-1:0]  err_code,
  output logic              err_pulse,
  output logic              pkt_done
);

  logic             beat_acc;
  beat_kind_e       beat_kind;
  logic             fr_in_pkt;
  logic [ERR_W-1:0] fr_viol;
  logic             fr_closes;

  pkt_beat_decode #(
    .CMD_W(CMD_W), .DATA_W(DATA_W),
    .CMD_OPEN(CMD_OPEN), .CMD_BODY(CMD_BODY), .CMD_CLOSE(CMD_CLOSE)
  ) u_dec (
    .valid(lnk_valid), .busy(lnk_busy), .cmd(lnk_cmd), .data(lnk_data),
    .accepted(beat_acc), .kind(beat_kind)
  );

  pkt_frame_fsm u_fsm (
    .clk(clk), .rst(rst), .accepted(beat_acc), .kind(beat_kind),
    .in_pkt(fr_in_pkt), .viol_code(fr_viol), .closes(fr_closes)
  );

  pkt_err_report u_rep (
    .clk(clk), .rst(rst), .viol_code(fr_viol), .closes(fr_closes),
    .err_flag(err_flag), .err_code(err_code),
    .err_pulse(err_pulse), .pkt_done(pkt_done)
  );

  a_r2_pulse_needs_beat: assert property (@(posedge clk) disable iff (rst)
    (err_pulse || pkt_done) |-> $past(beat_acc));

  a_r4_done_left_packet: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> !fr_in_pkt);

endmodule

// File: tb/pkt_frame_mon_tb.sv
module pkt_frame_mon_tb;

  localparam logic [23:0] C_OPEN  = 24'h000001;
  localparam logic [23:0] C_BODY  = 24'h000002;
  localparam logic [23:0] C_CLOSE = 24'h000003;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lnk_valid = 1'b0;
  logic        lnk_busy = 1'b0;
  logic [23:0] lnk_cmd = '0;
  logic [31:0] lnk_data = '0;
  logic        err_flag;
  logic [1:0]  err_code;
  logic        err_pulse;
  logic        pkt_done;

  int n_checks = 0;
  int n_errors = 0;

  // Reference state kept as plain integers.
  int    m_inside = 0;
  int    m_flag = 0;
  int    m_code = 0;
  int    m_epulse = 0;
  int    m_done = 0;
  string m_tag = "R1";

  always #2.5 clk = ~clk;

  pkt_frame_mon u_dut (
    .clk(clk), .rst(rst), .lnk_valid(lnk_valid), .lnk_busy(lnk_busy),
    .lnk_cmd(lnk_cmd), .lnk_data(lnk_data), .err_flag(err_flag),
    .err_code(err_code), .err_pulse(err_pulse), .pkt_done(pkt_done)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(m_tag, "err_flag", int'(err_flag), m_flag);
    check(m_tag, "err_code", int'(err_code), m_code);
    check(m_tag, "err_pulse", int'(err_pulse), m_epulse);
    check(m_tag, "pkt_done", int'(pkt_done), m_done);
  endtask

  task automatic flag_error(int code, string tag);
    m_flag = 1; m_code = code; m_epulse = 1; m_tag = tag;
  endtask

  // Drive one cycle, advance the model with the same inputs, compare after the edge.
  task automatic cyc(logic v, logic b, logic [23:0] c, logic [31:0] d);
    lnk_valid = v; lnk_busy = b; lnk_cmd = c; lnk_data = d;
    @(posedge clk);
    m_epulse = 0; m_done = 0;
    if (v && !b) begin
      if (c == C_OPEN) begin
        m_tag = "R10";
        if (m_inside != 0) flag_error(1, "R5");
        m_inside = 1;
      end else if (c == C_BODY) begin
        m_tag = "R3";
        if (m_inside == 0) flag_error(2, "R6");
      end else if (c == C_CLOSE) begin
        if (m_inside == 0) flag_error(2, "R6");
        else begin m_inside = 0; m_done = 1; m_tag = "R4"; end
      end else begin
        flag_error(3, "R7");
      end
    end else begin
      m_tag = "R2";
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    lnk_valid = 1'b0; lnk_busy = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_inside = 0; m_flag = 0; m_code = 0; m_epulse = 0; m_done = 0; m_tag = "R1";
    compare_all();
    rst = 1'b0;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R10: open as first beat; R4: empty packet then closes.
    cyc(1, 0, C_OPEN, 32'h1);
    cyc(1, 0, C_CLOSE, 32'h2);
    // R2: stalled garbage and idle garbage do nothing.
    cyc(1, 1, 24'hABCDEF, 32'hFFFF);
    cyc(0, 0, C_CLOSE, 32'h0);
    // Packet with three body beats and stalls in between (R3 data varies).
    cyc(1, 0, C_OPEN, 32'hDEAD);
    cyc(1, 1, C_OPEN, 32'h0);
    cyc(1, 0, C_BODY, 32'hBEEF);
    cyc(0, 1, 24'h777777, 32'h1);
    cyc(1, 0, C_BODY, 32'h0);
    cyc(1, 0, C_BODY, 32'hFFFFFFFF);
    cyc(1, 1, C_CLOSE, 32'h0);
    cyc(1, 0, C_CLOSE, 32'h5);
    if (err_flag !== 1'b0) $display("FAIL R4 clean run set flag: actual=%0d expected=0", err_flag);

    // R6: body and close outside a packet.
    cyc(1, 0, C_BODY, 32'h0);
    cyc(1, 0, C_CLOSE, 32'h0);
    // R8: stalled bad command must not change code 2.
    cyc(1, 1, 24'h000009, 32'h0);
    cyc(0, 0, C_OPEN, 32'h0);
    // R5: open inside a packet reopens; the close then completes.
    cyc(1, 0, C_OPEN, 32'h0);
    cyc(1, 0, C_OPEN, 32'h0);
    cyc(1, 0, C_CLOSE, 32'h0);
    // R7: bad commands inside and outside keep state.
    cyc(1, 0, 24'hFFFFFF, 32'h0);
    cyc(1, 0, C_OPEN, 32'h0);
    cyc(1, 0, 24'h000000, 32'h0);
    cyc(1, 0, C_BODY, 32'h0);
    cyc(1, 0, C_CLOSE, 32'h0);
    // R9: flag stays through quiet cycles.
    for (int i = 0; i < 5; i++) cyc(0, 0, 24'h0, 32'h0);

    // R1: reset clears the sticky flag and the code.
    do_reset();
    cyc(1, 0, C_CLOSE, 32'h0);
    do_reset();

    // Random mix of all beat kinds against the model.
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [23:0] c;
      r = $urandom_range(0, 9);
      c = (r < 3) ? C_BODY : (r < 6) ? C_OPEN : (r < 9) ? C_CLOSE : 24'($urandom);
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0), c, $urandom);
      if (i == 2000) do_reset();
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule